// File: doc/BRIEF.md
# Delta Sample Playback Channel

This block plays back a one-bit delta-modulated sample stored in memory. It fetches one byte at a time through a request/acknowledge read port, then spends a programmable number of clock cycles on each of the byte's eight bits. Each bit moves a signed seven-bit output level two steps up (bit 1) or two steps down (bit 0), clamped to the range -64 to +63. A downstream mixer takes the level as the channel's contribution.

Software sets the channel up through a write-strobe bus. The bus has four channel registers: mode, direct level, start block and length. A fifth select reaches a shared control register whose bit 4 starts and stops the channel. The start address and the byte count come from the start-block and length registers. When the last bit of the last byte has played, the channel either restarts the same sample (loop mode) or stops and raises an interrupt flag if interrupts are enabled.

The controller is a three-state machine. **IDLE** leaves on *start* to **FETCH**. **FETCH** holds the read request and leaves on *accept* (acknowledge seen) to **PLAY**, or on *stop* to **IDLE**. **PLAY** shifts bits out and takes one of four exits: *refill* (byte done, bytes remain) to **FETCH**, *wrap* (sample done, loop on) to **FETCH**, *finish* (sample done, loop off) to **IDLE**, or *stop* to **IDLE**.

Top module: `delta_sample_channel`

## Requirements
- R1: After reset the channel is inactive, the level is 0, the interrupt flag is clear and no read request is raised.
- R2: A write to select 1 sets the level to the written low seven bits minus 64, visible the cycle after the write. Bit 7 of the written value is ignored.
- R3: A write to select 4 with bit 4 set, while the channel is inactive, starts playback. The channel becomes active, the level goes to 0, the interrupt flag clears, and the first request reads address 0xC000 + 64 × (select-2 value), modulo 2^16.
- R4: One pass reads (select-3 value) × 16 + 1 bytes, at consecutive addresses that wrap modulo 2^16.
- R5: Bits are consumed least-significant first. A 1 adds 2 to the level and a 0 subtracts 2, saturating at +63 and -64.
- R6: Each bit lasts P clock cycles, where P is the rate-table entry chosen by bits 3..0 of select 0. Each bit is applied P cycles after the previous one, and the first bit P cycles after the acknowledge. The next request rises 8 × P cycles after the acknowledge, and the bit timer does not run while a request is waiting.
- R7: With loop off (select 0 bit 6 clear), the end of the last byte makes the channel inactive and sets the level to 0. It sets the interrupt flag exactly when select 0 bit 7 is set.
- R8: With loop on, the end of the last byte sets the level to 0. The channel stays active and re-requests the start address with a fresh byte count.
- R9: A write to select 0 with bit 7 clear clears the interrupt flag; one with bit 7 set leaves it. Any write to select 4 clears the flag.
- R10: A start write while the channel is active does not restart it, and the address sequence continues. A write to select 4 with bit 4 clear stops the channel: active and the request drop the next cycle.
- R11: A raised request stays high with a stable address until the acknowledge is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select: 0 mode, 1 level, 2 start block, 3 length, 4 shared control |
| wr_data | input | 8 | Write data |
| mem_req | output | 1 | Byte read request |
| mem_addr | output | ADDR_W | Byte read address |
| mem_ack | input | 1 | Read acknowledge; mem_data is valid in the same cycle |
| mem_data | input | 8 | Read data |
| level | output | 7 | Signed output level |
| active | output | 1 | Channel is playing or fetching |
| irq_pending | output | 1 | End-of-sample interrupt flag |

## Verification
The bench goes after four corner cases:
- **Level saturation.** Sustained runs of all-ones and all-zeros bytes push the level into both limits. A design without clamping wraps the level to the opposite sign.
- **Bit order and timing.** Every bit is checked at its exact cycle, with random acknowledge delays and the bit gap kept free of early requests. A reversed shift, or a bit timer that runs during a fetch, shows up as a wrong level or a request that arrives too early.
- **Address wrap and loop reload.** A sample starts near the top of the address space, and a looped sample must re-request its start address. A wrong length formula shows up as a wrong byte count.
- **Interrupt and enable rules.** The bench checks the flag's set and clear rules, and writes a start while the channel is active. A design that restarts there would jump back to the start address.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_PLAY
    } dsc_state_e;

    localparam int LVL_W   = 7;
    localparam int IDX_W   = 4;
    localparam int NRATES  = 1 << IDX_W;

    localparam logic [2:0] SEL_MODE   = 3'd0;
    localparam logic [2:0] SEL_LEVEL  = 3'd1;
    localparam logic [2:0] SEL_BLOCK  = 3'd2;
    localparam logic [2:0] SEL_LEN    = 3'd3;
    localparam logic [2:0] SEL_GLOBAL = 3'd4;

    function automatic logic signed [LVL_W-1:0] level_step(
        input logic signed [LVL_W-1:0] cur,
        input logic                    up
    );
        logic signed [LVL_W-1:0] r;
        if (up) begin
            r = (cur >= 7'sd62) ? 7'sd63 : cur + 7'sd2;
        end else begin
            r = (cur <= -7'sd63) ? -7'sd64 : cur - 7'sd2;
        end
        return r;
    endfunction

endpackage

// File: rtl/dsc_cfg_regs.sv
module dsc_cfg_regs
    import dsc_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = ADDR_W'(16'hC000),
    parameter int                LEN_W     = 13,
    parameter int                EN_BIT    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [7:0]        wr_data,
    output logic              irq_en,
    output logic              loop_en,
    output logic [IDX_W-1:0]  rate_idx,
    output logic [ADDR_W-1:0] start_addr,
    output logic [LEN_W-1:0]  start_len,
    output logic              level_wr,
    output logic              irq_clr_mode,
    output logic              global_wr,
    output logic              global_en
);

    logic [7:0] mode_q;
    logic [7:0] block_q;
    logic [7:0] len_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= '0;
            block_q <= '0;
            len_q   <= '0;
        end else if (wr_en) begin
            if (wr_sel == SEL_MODE)  mode_q  <= wr_data;
            if (wr_sel == SEL_BLOCK) block_q <= wr_data;
            if (wr_sel == SEL_LEN)   len_q   <= wr_data;
        end
    end

    always_comb begin
        irq_en       = mode_q[7];
        loop_en      = mode_q[6];
        rate_idx     = mode_q[IDX_W-1:0];
        start_addr   = BASE_ADDR + (ADDR_W'(block_q) << 6);
        start_len    = (LEN_W'(len_q) << 4) + LEN_W'(1);
        level_wr     = wr_en && (wr_sel == SEL_LEVEL);
        irq_clr_mode = wr_en && (wr_sel == SEL_MODE) && !wr_data[7];
        global_wr    = wr_en && (wr_sel == SEL_GLOBAL);
        global_en    = wr_data[EN_BIT];
    end

endmodule

// File: rtl/dsc_bit_timer.sv
module dsc_bit_timer
    import dsc_pkg::*;
#(
    parameter int                         RATE_W     = 16,
    parameter logic [NRATES*RATE_W-1:0]   RATE_TABLE = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             run,
    input  logic [IDX_W-1:0] rate_idx,
    output logic             tick
);

    logic [RATE_W-1:0] periods [NRATES];
    logic [RATE_W-1:0] cnt_q;
    logic [RATE_W-1:0] reload;

    for (genvar g = 0; g < NRATES; g++) begin : g_rate
        assign periods[g] = RATE_TABLE[g*RATE_W +: RATE_W];
    end

    assign reload = periods[rate_idx] - RATE_W'(1);
    assign tick   = run && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= reload;
        end else if (run) begin
            cnt_q <= (cnt_q == '0) ? reload : cnt_q - RATE_W'(1);
        end
    end

endmodule

// File: rtl/dsc_level.sv
module dsc_level
    import dsc_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic [LVL_W-1:0]        load_val,
    input  logic                    clear,
    input  logic                    step,
    input  logic                    up,
    output logic signed [LVL_W-1:0] level
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level <= '0;
        end else if (load) begin
            level <= $signed(load_val ^ 7'h40);
        end else if (clear) begin
            level <= '0;
        end else if (step) begin
            level <= level_step(level, up);
        end
    end

endmodule

// File: rtl/delta_sample_channel.sv
module delta_sample_channel
    import dsc_pkg::*;
#(
    parameter int                       ADDR_W     = 16,
    parameter logic [ADDR_W-1:0]        BASE_ADDR  = ADDR_W'(16'hC000),
    parameter int                       EN_BIT     = 4,
    parameter int                       RATE_W     = 16,
    parameter logic [NRATES*RATE_W-1:0] RATE_TABLE = {
        16'd54,  16'd72,  16'd84,  16'd106, 16'd128, 16'd142, 16'd160, 16'd190,
        16'd214, 16'd226, 16'd254, 16'd286, 16'd320, 16'd340, 16'd380, 16'd428
    }
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [2:0]              wr_sel,
    input  logic [7:0]              wr_data,
    output logic                    mem_req,
    output logic [ADDR_W-1:0]       mem_addr,
    input  logic                    mem_ack,
    input  logic [7:0]              mem_data,
    output logic signed [LVL_W-1:0] level,
    output logic                    active,
    output logic                    irq_pending
);

    localparam int LEN_W = 8 + 4 + 1;
    localparam int BIT_W = 3;

    dsc_state_e        state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  remain_q;
    logic [7:0]        shreg_q;
    logic [BIT_W-1:0]  bitcnt_q;
    logic              irq_q;

    logic              irq_en, loop_en, level_wr, irq_clr_mode, global_wr, global_en;
    logic [IDX_W-1:0]  rate_idx;
    logic [ADDR_W-1:0] start_addr;
    logic [LEN_W-1:0]  start_len;
    logic              tick;

    logic start, stop, accept, bit_go, byte_done, sample_done;

    dsc_cfg_regs #(
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR),
        .LEN_W     (LEN_W),
        .EN_BIT    (EN_BIT)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_sel       (wr_sel),
        .wr_data      (wr_data),
        .irq_en       (irq_en),
        .loop_en      (loop_en),
        .rate_idx     (rate_idx),
        .start_addr   (start_addr),
        .start_len    (start_len),
        .level_wr     (level_wr),
        .irq_clr_mode (irq_clr_mode),
        .global_wr    (global_wr),
        .global_en    (global_en)
    );

    always_comb begin
        start       = global_wr && global_en && (state_q == ST_IDLE);
        stop        = global_wr && !global_en;
        accept      = (state_q == ST_FETCH) && mem_ack && !stop;
        bit_go      = (state_q == ST_PLAY) && tick && !stop;
        byte_done   = bit_go && (bitcnt_q == BIT_W'(7));
        sample_done = byte_done && (remain_q == '0);
    end

    dsc_bit_timer #(
        .RATE_W     (RATE_W),
        .RATE_TABLE (RATE_TABLE)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .run      (state_q == ST_PLAY),
        .rate_idx (rate_idx),
        .tick     (tick)
    );

    dsc_level u_level (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (level_wr),
        .load_val (wr_data[LVL_W-1:0]),
        .clear    (start || sample_done),
        .step     (bit_go),
        .up       (shreg_q[0]),
        .level    (level)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions: start, accept, refill, wrap, finish, stop
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = ST_FETCH;
            end
            ST_FETCH: begin
                if (stop)        state_d = ST_IDLE;
                else if (accept) state_d = ST_PLAY;
            end
            ST_PLAY: begin
                if (stop)                       state_d = ST_IDLE;
                else if (sample_done && loop_en) state_d = ST_FETCH;
                else if (sample_done)           state_d = ST_IDLE;
                else if (byte_done)             state_d = ST_FETCH;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_req     = (state_q == ST_FETCH);
        mem_addr    = addr_q;
        active      = (state_q != ST_IDLE);
        irq_pending = irq_q;
    end

    // datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q   <= '0;
            remain_q <= '0;
            shreg_q  <= '0;
            bitcnt_q <= '0;
        end else if (start) begin
            addr_q   <= start_addr;
            remain_q <= start_len;
        end else if (accept) begin
            shreg_q  <= mem_data;
            addr_q   <= addr_q + ADDR_W'(1);
            remain_q <= remain_q - LEN_W'(1);
            bitcnt_q <= '0;
        end else if (bit_go) begin
            shreg_q  <= shreg_q >> 1;
            bitcnt_q <= bitcnt_q + BIT_W'(1);
            if (sample_done && loop_en) begin
                addr_q   <= start_addr;
                remain_q <= start_len;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else if (global_wr || irq_clr_mode) begin
            irq_q <= 1'b0;
        end else if (sample_done && !loop_en && irq_en) begin
            irq_q <= 1'b1;
        end
    end

endmodule

// File: rtl/dsc_checker.sv
module dsc_checker #(
    parameter int ADDR_W = 16,
    parameter int EN_BIT = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [2:0]        wr_sel,
    input logic [7:0]        wr_data,
    input logic              mem_req,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic signed [6:0] level,
    input logic              active,
    input logic              irq_pending
);

    logic signed [7:0] lvl8;
    logic              stop_wr;
    assign lvl8    = {level[6], level};
    assign stop_wr = wr_en && (wr_sel == 3'd4) && !wr_data[EN_BIT];

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !mem_req);

    assert_level_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 3'd1) |=> level == $signed($past(wr_data[6:0]) ^ 7'h40));

    assert_level_small_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !wr_en) |=> (level == 7'sd0) ||
            ((lvl8 - $past(lvl8) <= 8'sd2) && (lvl8 - $past(lvl8) >= -8'sd2)));

    assert_irq_on_finish_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_pending) |-> $fell(active));

    assert_irq_only_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pending |-> !active);

    assert_global_clears_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 3'd4) |=> !irq_pending);

    assert_stop_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_wr |=> !active && !mem_req);

    assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !stop_wr) |=> mem_req && $stable(mem_addr));

endmodule

bind delta_sample_channel dsc_checker #(
    .ADDR_W (ADDR_W),
    .EN_BIT (EN_BIT)
) u_dsc_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_sel      (wr_sel),
    .wr_data     (wr_data),
    .mem_req     (mem_req),
    .mem_ack     (mem_ack),
    .mem_addr    (mem_addr),
    .level       (level),
    .active      (active),
    .irq_pending (irq_pending)
);

// File: tb/delta_sample_channel_test.sv
module delta_sample_channel_test;

    function automatic logic [255:0] build_rates();
        logic [255:0] r;
        r = '0;
        for (int i = 0; i < 16; i++) r[i*16 +: 16] = 16'(i + 2);
        return r;
    endfunction

    localparam logic [255:0] TB_RATES = build_rates();

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [2:0]        wr_sel = '0;
    logic [7:0]        wr_data = '0;
    logic              mem_req;
    logic [15:0]       mem_addr;
    logic              mem_ack = 1'b0;
    logic [7:0]        mem_data = '0;
    logic signed [6:0] level;
    logic              active;
    logic              irq_pending;

    int errors = 0;
    int checks = 0;
    int exp_level = 0;
    int pattern = 0;

    always #4 clk = ~clk;

    delta_sample_channel #(.RATE_TABLE(TB_RATES)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_sel      (wr_sel),
        .wr_data     (wr_data),
        .mem_req     (mem_req),
        .mem_addr    (mem_addr),
        .mem_ack     (mem_ack),
        .mem_data    (mem_data),
        .level       (level),
        .active      (active),
        .irq_pending (irq_pending)
    );

    function automatic int period_of(int idx);
        return idx + 2;
    endfunction

    function automatic int step_model(int cur, bit up);
        int r;
        r = up ? cur + 2 : cur - 2;
        if (r > 63)  r = 63;
        if (r < -64) r = -64;
        return r;
    endfunction

    function automatic logic [7:0] mem_byte(logic [15:0] a);
        if (pattern == 1) return 8'hFF;
        if (pattern == 2) return 8'h00;
        return (a[7:0] * 8'd29) ^ a[15:8] ^ 8'h5A;
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic write_reg(logic [2:0] sel, logic [7:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic serve_byte(int exp_addr, int p, bit last, bit loop_on, bit irq_on, bit poke);
        int d;
        logic [7:0] b;
        chk("R11 request up", int'(mem_req), 1);
        chk("R4 fetch address", int'(mem_addr), exp_addr);
        d = $urandom_range(0, 3);
        for (int i = 0; i < d; i++) begin
            @(negedge clk);
            chk("R11 request held", int'(mem_req), 1);
            chk("R11 address stable", int'(mem_addr), exp_addr);
        end
        b = mem_byte(mem_addr);
        mem_data = b;
        mem_ack = 1'b1;
        for (int c = 1; c <= 8 * p + 1; c++) begin
            @(negedge clk);
            if (c == 1) begin
                mem_ack = 1'b0;
                if (poke) begin
                    wr_en = 1'b1; wr_sel = 3'd4; wr_data = 8'h10;
                end
            end
            if (c == 2 && poke) wr_en = 1'b0;
            if (c == 8 * p) chk("R6 no request during bits", int'(mem_req), 0);
            if (c > 1 && ((c - 1) % p) == 0) begin
                int k;
                k = (c - 1) / p;
                exp_level = step_model(exp_level, b[k-1]);
                if (k == 8 && last) exp_level = 0;
                chk("R5 level after bit", int'($signed(level)), exp_level);
            end
        end
        if (last && !loop_on) begin
            chk("R7 inactive at end", int'(active), 0);
            chk("R7 irq at end", int'(irq_pending), int'(irq_on));
        end else begin
            chk("R6 next request timing", int'(mem_req), 1);
            if (last) chk("R8 active across loop", int'(active), 1);
        end
    endtask

    task automatic play(logic [7:0] r0, logic [7:0] r2, logic [7:0] r3,
                        int iters, int poke_at, bit stop_after);
        int n, p, base;
        write_reg(3'd0, r0);
        write_reg(3'd2, r2);
        write_reg(3'd3, r3);
        write_reg(3'd4, 8'h10);
        base = (32'hC000 + int'(r2) * 64) & 32'hFFFF;
        chk("R3 active on start", int'(active), 1);
        chk("R3 level zero on start", int'($signed(level)), 0);
        chk("R3 irq cleared on start", int'(irq_pending), 0);
        chk("R3 first address", int'(mem_addr), base);
        exp_level = 0;
        n = int'(r3) * 16 + 1;
        p = period_of(int'(r0[3:0]));
        for (int it = 0; it < iters; it++) begin
            for (int i = 0; i < n; i++) begin
                serve_byte((base + i) & 32'hFFFF, p, i == n - 1, r0[6], r0[7], i == poke_at);
            end
        end
        if (stop_after) begin
            write_reg(3'd4, 8'h00);
            chk("R10 stop clears active", int'(active), 0);
            chk("R10 stop drops request", int'(mem_req), 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset active", int'(active), 0);
        chk("R1 reset level", int'($signed(level)), 0);
        chk("R1 reset irq", int'(irq_pending), 0);
        chk("R1 reset request", int'(mem_req), 0);

        // R2 direct level loads
        write_reg(3'd1, 8'h00); chk("R2 level 0", int'($signed(level)), -64);
        write_reg(3'd1, 8'h7F); chk("R2 level 127", int'($signed(level)), 63);
        write_reg(3'd1, 8'h40); chk("R2 level 64", int'($signed(level)), 0);
        write_reg(3'd1, 8'h85); chk("R2 bit7 ignored", int'($signed(level)), -59);

        // one-byte sample with irq, then clear rules (R7, R9)
        play(8'h80, 8'h00, 8'h00, 1, -1, 1'b0);
        write_reg(3'd0, 8'h81);
        chk("R9 mode write with bit7 keeps irq", int'(irq_pending), 1);
        write_reg(3'd0, 8'h01);
        chk("R9 mode write without bit7 clears irq", int'(irq_pending), 0);
        play(8'h83, 8'h10, 8'h00, 1, -1, 1'b0);
        write_reg(3'd4, 8'h00);
        chk("R9 global write clears irq", int'(irq_pending), 0);
        chk("R9 still inactive", int'(active), 0);
        play(8'h82, 8'h21, 8'h00, 1, -1, 1'b0);

        // no irq when disabled (R7)
        play(8'h04, 8'h33, 8'h00, 1, -1, 1'b0);

        // saturation high and low (R5) over 17 bytes
        pattern = 1;
        play(8'h00, 8'h02, 8'h01, 1, -1, 1'b0);
        pattern = 2;
        play(8'h01, 8'h03, 8'h01, 1, -1, 1'b0);
        pattern = 0;

        // start while active is ignored (R10)
        play(8'h02, 8'h40, 8'h01, 1, 3, 1'b0);

        // loop twice then stop (R8, R10)
        play(8'h45, 8'h55, 8'h00, 2, -1, 1'b1);
        // loop with irq enabled must not raise irq (R8)
        play(8'hC0, 8'h56, 8'h00, 2, -1, 1'b1);
        chk("R8 no irq while looping", int'(irq_pending), 0);

        // stop in the middle of a sample (R10)
        play(8'h00, 8'h60, 8'h01, 0, -1, 1'b0);
        for (int i = 0; i < 2; i++) serve_byte(16'hD800 + i, 2, 1'b0, 1'b0, 1'b0, 1'b0);
        write_reg(3'd4, 8'h00);
        chk("R10 mid-sample stop", int'(active), 0);
        chk("R10 mid-sample request", int'(mem_req), 0);

        // address wrap across the top (R4)
        play(8'h00, 8'hFF, 8'h04, 1, -1, 1'b0);

        // random configurations
        for (int t = 0; t < 6; t++) begin
            logic [7:0] r0;
            r0 = {1'($urandom_range(0, 1)), 3'b000, 4'($urandom_range(0, 15))};
            play(r0, 8'($urandom_range(0, 255)), 8'($urandom_range(0, 1)), 1, -1, 1'b0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule